// File: doc/BRIEF.md
# Checkpointed Register File with Shadow Copy

This block holds a processor's general-purpose registers together with a second, shadow copy of them. The shadow copy makes speculative execution cheap to undo. The registers are organised as a number of sets of sixteen entries, and the number of sets is a parameter. In normal operation the block behaves as an ordinary register file with two combinational read ports and one write port.

When the controller raises a checkpoint request, the block does three things:
- It latches the current program counter.
- It walks the live registers into the shadow storage, a fixed number of registers per cycle.
- It holds a busy (stall) output high for the duration of the copy, and pulses a done signal once the snapshot is complete.

After that, speculation is in progress. A commit strobe throws the snapshot away and leaves the live registers as they are. A rollback strobe restores every register in one cycle and presents the saved program counter along with a one-cycle valid pulse, so the fetch stage can resume from the checkpoint.

Top module: `shadow_ckpt_rf`

## Requirements
- R1: After reset every register reads 0, and `ckptBusy`, `ckptDone` and `restorePcValid` are all low.
- R2: Both read ports return a register's contents combinationally. A write with `wrEn` high lands at the next rising edge unless a copy is in progress. Every register from address 0 to SET_COUNT*16-1 is reachable.
- R3: A `ckptBegin` sampled while idle raises `ckptBusy` from the next cycle. `ckptBusy` then stays high for exactly SET_COUNT*16/COPY_PER_CYCLE cycles. Writes presented while `ckptBusy` is high are ignored.
- R4: `ckptDone` is high for exactly one cycle: the cycle right after the last register group is copied, which is also the first cycle with `ckptBusy` low again.
- R5: A `commitStb` during speculation leaves all live registers unchanged, gives no `restorePcValid` pulse, and returns the block to idle.
- R6: A `rollbackStb` during speculation has three effects from the next cycle on. Every register reads the value it held when the snapshot was taken. `restorePc` equals the `curPc` sampled with `ckptBegin`. `restorePcValid` is high for that one cycle only.
- R7: When `commitStb` and `rollbackStb` are high in the same speculative cycle, the rollback is carried out.
- R8: `commitStb` and `rollbackStb` have no effect outside speculation, and `ckptBegin` has no effect unless the block is idle.
- R9: SET_COUNT is limited to the range 2 to 32, and the total register count must be a multiple of COPY_PER_CYCLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | ADDR_W | Read port A address |
| rdDataA | output | DATA_W | Read port A data |
| rdAddrB | input | ADDR_W | Read port B address |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | Write enable |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| curPc | input | PC_W | Program counter to save at checkpoint |
| ckptBegin | input | 1 | Checkpoint request |
| ckptBusy | output | 1 | Copy in progress; pipeline must stall |
| ckptDone | output | 1 | One-cycle pulse when snapshot is complete |
| commitStb | input | 1 | Discard the snapshot |
| rollbackStb | input | 1 | Restore registers and PC from the snapshot |
| restorePc | output | PC_W | Saved program counter |
| restorePcValid | output | 1 | One-cycle pulse following a rollback |

## Verification
Read data is combinational, so it is sampled in the same cycle as the address. A write, a commit or a rollback shows up one edge later. The bench drives every stimulus just after a rising edge and samples just after the following one. The busy window is measured by counting the post-edge samples that show `ckptBusy` high, starting with the sample taken right after the edge that accepted `ckptBegin`; eight are expected with the default parameters. `ckptDone` and `restorePcValid` are checked high in the single sample that follows their triggering edge and low in the sample after that.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  localparam int MAX_CHUNK_W = 10;

  typedef struct packed {
    logic                   copyEn;
    logic [MAX_CHUNK_W-1:0] copyIdx;
    logic                   capturePc;
    logic                   restore;
    logic                   blockWrite;
  } ctrlStrobes_t;
endpackage

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
  import ckpt_pkg::*;
#(
  parameter int NUM_CHUNKS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ckptBegin,
  input  logic         commitStb,
  input  logic         rollbackStb,
  output ctrlStrobes_t strobes,
  output logic         ckptBusy,
  output logic         ckptDone,
  output logic         restorePcValid
);
  localparam int CHUNK_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_COPY, ST_DONE, ST_SPEC} ckptState_t;

  ckptState_t         state;
  logic [CHUNK_W-1:0] chunkCnt;
  logic               lastChunk;
  logic               specEnd;

  assign lastChunk = (chunkCnt == CHUNK_W'(NUM_CHUNKS - 1));
  assign specEnd   = (state == ST_SPEC) && (commitStb || rollbackStb);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      chunkCnt       <= '0;
      restorePcValid <= 1'b0;
    end else begin
      restorePcValid <= (state == ST_SPEC) && rollbackStb;
      unique case (state)
        ST_IDLE: if (ckptBegin) begin
          state    <= ST_COPY;
          chunkCnt <= '0;
        end
        ST_COPY: begin
          chunkCnt <= chunkCnt + 1'b1;
          if (lastChunk) state <= ST_DONE;
        end
        ST_DONE: state <= ST_SPEC;
        ST_SPEC: if (specEnd) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.copyEn     = (state == ST_COPY);
    strobes.copyIdx    = MAX_CHUNK_W'(chunkCnt);
    strobes.capturePc  = (state == ST_IDLE) && ckptBegin;
    strobes.restore    = (state == ST_SPEC) && rollbackStb;
    strobes.blockWrite = (state == ST_COPY);
  end

  assign ckptBusy = (state == ST_COPY);
  assign ckptDone = (state == ST_DONE);

  AST_BEGIN_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (!ckptBusy && !ckptDone && state == ST_IDLE && ckptBegin) |=> ckptBusy); // R3
  AST_DONE_AFTER_COPY: assert property (@(posedge clk) disable iff (!rstN)
    ckptDone |-> ($past(ckptBusy) && !ckptBusy)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ckptDone |=> !ckptDone); // R4
  AST_ROLLBACK_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SPEC && commitStb && rollbackStb) |=> restorePcValid); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    restorePcValid |=> !restorePcValid); // R6
  AST_NO_END_OUTSIDE_SPEC: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_SPEC) |=> !restorePcValid); // R8
endmodule

// File: rtl/ckpt_datapath.sv
module ckpt_datapath
  import ckpt_pkg::*;
#(
  parameter int NUM_REGS       = 32,
  parameter int DATA_W         = 32,
  parameter int PC_W           = 32,
  parameter int COPY_PER_CYCLE = 4,
  parameter int ADDR_W         = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PC_W-1:0]   curPc,
  output logic [PC_W-1:0]   restorePc
);
  logic [DATA_W-1:0] liveRegs   [NUM_REGS];
  logic [DATA_W-1:0] shadowRegs [NUM_REGS];
  logic [PC_W-1:0]   shadowPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) liveRegs[i] <= '0;
    end else if (strobes.restore) begin
      for (int i = 0; i < NUM_REGS; i++) liveRegs[i] <= shadowRegs[i];
    end else if (wrEn && !strobes.blockWrite) begin
      liveRegs[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) shadowRegs[i] <= '0;
      shadowPc <= '0;
    end else begin
      if (strobes.capturePc) shadowPc <= curPc;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strobes.copyEn && ((i / COPY_PER_CYCLE) == int'(strobes.copyIdx)))
          shadowRegs[i] <= liveRegs[i];
      end
    end
  end

  assign rdDataA   = liveRegs[rdAddrA];
  assign rdDataB   = liveRegs[rdAddrB];
  assign restorePc = shadowPc;

  AST_NO_WRITE_WHILE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.blockWrite && wrEn) |=> (liveRegs[$past(wrAddr)] == $past(liveRegs[wrAddr]))); // R3
  AST_RESTORE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restore |=> (liveRegs[0] == $past(shadowRegs[0]))); // R6
  AST_RESTORE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restore |=> (liveRegs[NUM_REGS-1] == $past(shadowRegs[NUM_REGS-1]))); // R6
endmodule

// File: rtl/shadow_ckpt_rf.sv
module shadow_ckpt_rf
  import ckpt_pkg::*;
#(
  parameter int SET_COUNT      = 2,
  parameter int DATA_W         = 32,
  parameter int PC_W           = 32,
  parameter int COPY_PER_CYCLE = 4,
  localparam int NUM_REGS      = SET_COUNT * 16,
  localparam int ADDR_W        = $clog2(NUM_REGS),
  localparam int NUM_CHUNKS    = NUM_REGS / COPY_PER_CYCLE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PC_W-1:0]   curPc,
  input  logic              ckptBegin,
  output logic              ckptBusy,
  output logic              ckptDone,
  input  logic              commitStb,
  input  logic              rollbackStb,
  output logic [PC_W-1:0]   restorePc,
  output logic              restorePcValid
);
  ctrlStrobes_t strobes;

  initial begin
    AST_SET_RANGE: assert (SET_COUNT >= 2 && SET_COUNT <= 32); // R9
    AST_CHUNK_EVEN: assert (NUM_REGS % COPY_PER_CYCLE == 0); // R9
  end

  ckpt_ctrl #(.NUM_CHUNKS(NUM_CHUNKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .ckptBegin(ckptBegin), .commitStb(commitStb),
    .rollbackStb(rollbackStb), .strobes(strobes), .ckptBusy(ckptBusy),
    .ckptDone(ckptDone), .restorePcValid(restorePcValid)
  );

  ckpt_datapath #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PC_W(PC_W),
    .COPY_PER_CYCLE(COPY_PER_CYCLE), .ADDR_W(ADDR_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .curPc(curPc), .restorePc(restorePc)
  );
endmodule

// File: tb/shadow_ckpt_rf_bench.sv
module shadow_ckpt_rf_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, curPc = '0, restorePc;
  logic        wrEn = 1'b0, ckptBegin = 1'b0, commitStb = 1'b0, rollbackStb = 1'b0;
  logic        ckptBusy, ckptDone, restorePcValid;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] model [32];

  localparam logic [36:0] VEC [8] = '{
    {5'd0,  32'h1111_0000}, {5'd1,  32'h2222_0001}, {5'd3,  32'h3333_0003},
    {5'd5,  32'h4444_0005}, {5'd7,  32'h5555_0007}, {5'd8,  32'h6666_0008},
    {5'd16, 32'h7777_0010}, {5'd31, 32'h8888_001F}
  };

  always #5 clk = ~clk;

  shadow_ckpt_rf u_shadow_ckpt_rf (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .curPc(curPc), .ckptBegin(ckptBegin), .ckptBusy(ckptBusy),
    .ckptDone(ckptDone), .commitStb(commitStb), .rollbackStb(rollbackStb),
    .restorePc(restorePc), .restorePcValid(restorePcValid)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readCheck(input logic [4:0] a, input string req);
    rdAddrA = a; rdAddrB = a; #1;
    check(rdDataA == model[a] && rdDataB == model[a], req, rdDataA, model[a]);
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d; tick(); wrEn = 1'b0;
  endtask

  task automatic takeCkpt(input logic [31:0] pc);
    curPc = pc; ckptBegin = 1'b1; tick(); ckptBegin = 1'b0;
    for (int n = 0; n < 9; n++) tick();
  endtask

  initial begin
    #200000;
    testsFailed++; testsRun++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int busyCycles;
    logic [31:0] snap [32];
    for (int i = 0; i < 32; i++) model[i] = '0;
    tick(); tick(); rstN = 1'b1; tick();

    // R1 reset state
    readCheck(5'd31, "R1 reg31 after reset");
    check(!ckptBusy && !ckptDone && !restorePcValid, "R1 control outputs",
          {29'd0, ckptBusy, ckptDone, restorePcValid}, 32'd0);

    // R2 vector table: write then read on both ports
    for (int v = 0; v < 8; v++) begin
      writeReg(VEC[v][36:32], VEC[v][31:0]);
      model[VEC[v][36:32]] = VEC[v][31:0];
      readCheck(VEC[v][36:32], "R2 write/read");
    end

    // R3 checkpoint: busy window length, blocked writes
    for (int i = 0; i < 32; i++) snap[i] = model[i];
    curPc = 32'h0000_1000; ckptBegin = 1'b1; tick(); ckptBegin = 1'b0;
    check(ckptBusy, "R3 busy after begin", {31'd0, ckptBusy}, 32'd1);
    wrEn = 1'b1; wrAddr = 5'd3; wrData = 32'hDEAD_BEEF;
    busyCycles = 0;
    while (ckptBusy && busyCycles < 100) begin busyCycles++; tick(); end
    wrEn = 1'b0;
    check(busyCycles == 8, "R3 busy length", busyCycles, 32'd8);
    check(ckptDone, "R4 done after copy", {31'd0, ckptDone}, 32'd1);
    readCheck(5'd3, "R3 write during copy ignored");
    tick();
    check(!ckptDone, "R4 done one cycle", {31'd0, ckptDone}, 32'd0);

    // R6 rollback restores registers and PC
    writeReg(5'd3, 32'h0000_0055); writeReg(5'd31, 32'h0000_0066);
    rollbackStb = 1'b1; tick(); rollbackStb = 1'b0;
    check(restorePcValid, "R6 valid pulse", {31'd0, restorePcValid}, 32'd1);
    check(restorePc == 32'h0000_1000, "R6 restored pc", restorePc, 32'h0000_1000);
    readCheck(5'd3, "R6 reg3 restored");
    readCheck(5'd31, "R6 reg31 restored");
    tick();
    check(!restorePcValid, "R6 valid one cycle", {31'd0, restorePcValid}, 32'd0);

    // R5 commit keeps live values; R8 later rollback ignored
    takeCkpt(32'h0000_2000);
    writeReg(5'd7, 32'hABCD_0007); model[7] = 32'hABCD_0007;
    commitStb = 1'b1; tick(); commitStb = 1'b0;
    check(!restorePcValid, "R5 no valid on commit", {31'd0, restorePcValid}, 32'd0);
    readCheck(5'd7, "R5 reg7 kept");
    rollbackStb = 1'b1; tick(); rollbackStb = 1'b0;
    readCheck(5'd7, "R8 rollback while idle ignored");
    check(!restorePcValid, "R8 no valid while idle", {31'd0, restorePcValid}, 32'd0);

    // R8 begin during speculation ignored; R7 rollback wins on conflict
    takeCkpt(32'h0000_3000);
    writeReg(5'd8, 32'h0BAD_0008);
    curPc = 32'h0000_4000; ckptBegin = 1'b1; tick(); ckptBegin = 1'b0;
    check(!ckptBusy, "R8 begin during speculation ignored", {31'd0, ckptBusy}, 32'd0);
    $display("note: commit and rollback raised together (conflict expected to resolve as rollback)");
    commitStb = 1'b1; rollbackStb = 1'b1; tick(); commitStb = 1'b0; rollbackStb = 1'b0;
    check(restorePcValid, "R7 rollback taken", {31'd0, restorePcValid}, 32'd1);
    check(restorePc == 32'h0000_3000, "R7 pc of checkpoint", restorePc, 32'h0000_3000);
    readCheck(5'd8, "R7 reg8 restored");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule